// File: doc/BRIEF.md
# Bus Command Reset Sequencer

This block sits behind the register write path of a serial slave interface. It watches each byte write and looks for a two-write unlock key: the byte 0x55 written twice in a row to register address 0x1D. When the key completes while the reset-enable bit is set, the block performs a one-time factory-style reset of the logging state.

The reset runs in a fixed order. First, one clear pulse goes to the elapsed-time counter, to the event counter, and to the flag bits: the alarm flag, the reset-enable bit and the event-count top bit. In the same cycle the configuration register becomes read-only. Next, a commit request asks the storage controller to save the new state, and the block waits for the controller to report completion.

After the reset, the block ignores every further key for as long as power stays up. Only a power-up load, which is the synchronous reset of this block, releases the lock.

Top module: `cmd_reset_seq`

## Requirements
- R1: After reset (rst_n low at a clock edge), clr_timer, clr_events, clr_flags, cfg_lock, commit_req and busy are all 0.
- R2: Two consecutive accepted writes of data 0x55 to address 0x1D, with reset_en 1 on the second, make clr_timer, clr_events and clr_flags all 1 for exactly the one cycle after the second write's clock edge. In that same cycle busy and cfg_lock become 1.
- R3: Any write that is not data 0x55 to address 0x1D returns the detector to idle. After such a write, a single further key write does not trigger a reset, and two further key writes do.
- R4: If reset_en is 0 on the completing key write, nothing is cleared and the detector returns to idle. A later reset then needs two fresh key writes.
- R5: commit_req rises in the cycle right after the clear pulse. It stays 1 until commit_done is sampled high, and busy stays 1 throughout. After that edge, commit_req and busy are both 0.
- R6: Writes that arrive while busy is 1, including key writes, are discarded. They produce no further clear pulse and do not end the commit request.
- R7: Once a reset has been performed, cfg_lock stays 1. Any later key sequence with reset_en 1 produces no clear pulse and no commit request.
- R8: Only rst_n clears cfg_lock and re-arms the reset command.
- R9: Cycles with wr_en 0 between the two key writes do not break the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-up load |
| wr_en | input | 1 | Write strobe, one cycle per byte write |
| wr_addr | input | 5 | Register address of the write |
| wr_data | input | 8 | Data byte of the write |
| reset_en | input | 1 | Current value of the reset-enable configuration bit |
| commit_done | input | 1 | Storage controller finished the commit |
| clr_timer | output | 1 | One-cycle clear for the elapsed-time counter |
| clr_events | output | 1 | One-cycle clear for the event counter |
| clr_flags | output | 1 | One-cycle clear for the alarm flag, reset-enable and event-count top bit |
| cfg_lock | output | 1 | Configuration register is read-only |
| commit_req | output | 1 | Request to save the state to nonvolatile storage |
| busy | output | 1 | Reset sequence is in progress and writes are discarded |

## Verification
The hardest case to reach from the ports is a key write that lands right after a near miss. An earlier write may have left the detector halfway through the key, so every sweep point starts from a fresh power-up load, and no leftover partial match can masquerade as a decoding fault. The bench sweeps all 256 values of the first byte at the key address and all 32 addresses of a 0x55 first write. For each point, the expected outcome is worked out from the key values alone. Separate sequences place key writes inside the commit window and after completion, where the only visible evidence is the missing clear pulse.

// File: rtl/rst_seq_pkg.sv
// Package: shared state encoding for the bus command reset sequencer.
// Assumes: nothing beyond a single clock domain.
package rst_seq_pkg;

    // Sequencer phases, in the order they are visited after a key.
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_CLEAR  = 2'd1,
        ST_COMMIT = 2'd2,
        ST_DONE   = 2'd3
    } seq_state_t;

endpackage

// File: rtl/rst_key_match.sv
// Module: rst_key_match
// Counts consecutive key writes (KEY_DATA to KEY_ADDR) and raises fire
// combinationally on the completing write when permit is set.
// Assumes: wr_en is a one-cycle strobe per write; accept low discards writes.
module rst_key_match #(
    parameter int          ADDR_W     = 5,
    parameter int          DATA_W     = 8,
    parameter logic [ADDR_W-1:0] KEY_ADDR = 5'h1D,
    parameter logic [DATA_W-1:0] KEY_DATA = 8'h55,
    parameter int          KEY_WRITES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              permit,
    output logic              fire
);
    localparam int CNT_W = $clog2(KEY_WRITES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(KEY_WRITES - 1);

    logic [CNT_W-1:0] hits;
    logic             is_key;
    logic             at_last;

    // Decode whether the current write carries the key.
    always_comb begin
        is_key  = (wr_addr == KEY_ADDR) && (wr_data == KEY_DATA);
        at_last = (hits == LAST);
        fire    = accept && wr_en && is_key && at_last && permit;
    end

    // Track how many key writes have arrived back to back.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hits <= '0;
        end else if (!accept) begin
            hits <= '0;
        end else if (wr_en) begin
            if (is_key && !at_last)
                hits <= hits + 1'b1;
            else
                hits <= '0;
        end
    end
endmodule

// File: rtl/rst_commit_fsm.sv
// Module: rst_commit_fsm
// Walks idle -> clear -> commit -> done once per power-up.
// Assumes: commit_done is only meaningful while the commit is requested.
module rst_commit_fsm
    import rst_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fire,
    input  logic       commit_done,
    output seq_state_t state,
    output logic       accept
);
    seq_state_t nxt;

    // Next-state selection.
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (fire) nxt = ST_CLEAR;
            ST_CLEAR:  nxt = ST_COMMIT;
            ST_COMMIT: if (commit_done) nxt = ST_DONE;
            ST_DONE:   nxt = ST_DONE;
            default:   nxt = ST_IDLE;
        endcase
    end

    // State register; only the power-up load leaves ST_DONE.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Writes count toward a key only before any reset has started.
    always_comb accept = (state == ST_IDLE);
endmodule

// File: rtl/rst_out_decode.sv
// Module: rst_out_decode
// Maps the sequencer phase onto the clear, lock, commit and busy outputs.
// Assumes: state is a registered value, so the outputs are glitch-free.
module rst_out_decode
    import rst_seq_pkg::*;
(
    input  seq_state_t state,
    output logic       clr_timer,
    output logic       clr_events,
    output logic       clr_flags,
    output logic       cfg_lock,
    output logic       commit_req,
    output logic       busy
);
    // Decode each output from the current phase.
    always_comb begin
        clr_timer  = (state == ST_CLEAR);
        clr_events = (state == ST_CLEAR);
        clr_flags  = (state == ST_CLEAR);
        cfg_lock   = (state != ST_IDLE);
        commit_req = (state == ST_COMMIT);
        busy       = (state == ST_CLEAR) || (state == ST_COMMIT);
    end
endmodule

// File: rtl/cmd_reset_seq.sv
// Module: cmd_reset_seq (top)
// Recognizes the two-write reset key, clears the logging state once,
// locks the configuration and asks for a nonvolatile commit.
// Assumes: rst_n is the power-up load; writes are decoded upstream.
module cmd_reset_seq
    import rst_seq_pkg::*;
#(
    parameter int ADDR_W     = 5,
    parameter int DATA_W     = 8,
    parameter logic [ADDR_W-1:0] KEY_ADDR = 5'h1D,
    parameter logic [DATA_W-1:0] KEY_DATA = 8'h55,
    parameter int KEY_WRITES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              reset_en,
    input  logic              commit_done,
    output logic              clr_timer,
    output logic              clr_events,
    output logic              clr_flags,
    output logic              cfg_lock,
    output logic              commit_req,
    output logic              busy
);
    logic       fire;
    logic       accept;
    seq_state_t state;

    rst_key_match #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .KEY_ADDR  (KEY_ADDR),
        .KEY_DATA  (KEY_DATA),
        .KEY_WRITES(KEY_WRITES)
    ) u_match (
        .clk    (clk),
        .rst_n  (rst_n),
        .accept (accept),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .permit (reset_en),
        .fire   (fire)
    );

    rst_commit_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .fire       (fire),
        .commit_done(commit_done),
        .state      (state),
        .accept     (accept)
    );

    rst_out_decode u_out (
        .state     (state),
        .clr_timer (clr_timer),
        .clr_events(clr_events),
        .clr_flags (clr_flags),
        .cfg_lock  (cfg_lock),
        .commit_req(commit_req),
        .busy      (busy)
    );
endmodule

// File: rtl/cmd_reset_seq_chk.sv
// Module: cmd_reset_seq_chk
// Port-level protocol checks for cmd_reset_seq, attached by bind.
// Assumes: observes ports only.
module cmd_reset_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic commit_done,
    input logic clr_timer,
    input logic clr_events,
    input logic clr_flags,
    input logic cfg_lock,
    input logic commit_req,
    input logic busy
);
    logic lock_seen;

    // Remember that the lock has been observed since the power-up load.
    always_ff @(posedge clk) begin
        if (!rst_n)        lock_seen <= 1'b0;
        else if (cfg_lock) lock_seen <= 1'b1;
    end

    a_r2_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        clr_timer |=> !clr_timer);
    a_r2_clear_locks: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_timer || clr_events || clr_flags) |-> (cfg_lock && busy));
    a_r5_req_follows: assert property (@(posedge clk) disable iff (!rst_n)
        clr_events |=> commit_req);
    a_r5_req_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_req && !commit_done) |=> commit_req);
    a_r5_req_busy: assert property (@(posedge clk) disable iff (!rst_n)
        commit_req |-> busy);
    a_r7_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_lock |=> cfg_lock);
    a_r7_one_clear: assert property (@(posedge clk) disable iff (!rst_n)
        lock_seen |-> !clr_flags);
endmodule

bind cmd_reset_seq cmd_reset_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .commit_done(commit_done),
    .clr_timer  (clr_timer),
    .clr_events (clr_events),
    .clr_flags  (clr_flags),
    .cfg_lock   (cfg_lock),
    .commit_req (commit_req),
    .busy       (busy)
);

// File: tb/test_cmd_reset_seq.sv
`timescale 1ns/1ps
module test_cmd_reset_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [4:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       reset_en = 1'b0;
    logic       commit_done = 1'b0;
    logic       clr_timer, clr_events, clr_flags, cfg_lock, commit_req, busy;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    localparam logic [4:0] KA = 5'h1D;
    localparam logic [7:0] KD = 8'h55;

    always #2.5 clk = ~clk;

    cmd_reset_seq i_cmd_reset_seq (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .reset_en(reset_en), .commit_done(commit_done),
        .clr_timer(clr_timer), .clr_events(clr_events), .clr_flags(clr_flags),
        .cfg_lock(cfg_lock), .commit_req(commit_req), .busy(busy)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Packs outputs as {clr_timer,clr_events,clr_flags,cfg_lock,commit_req,busy}.
    function automatic int outs();
        return {clr_timer, clr_events, clr_flags, cfg_lock, commit_req, busy};
    endfunction

    task automatic expect_outs(input int exp, input string tag);
        check(outs() == exp, tag, outs(), exp);
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic power_up();
        rst_n = 1'b0;
        tick();
        tick();
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d, input logic re);
        wr_en = 1'b1; wr_addr = a; wr_data = d; reset_en = re;
        tick();
        wr_en = 1'b0; reset_en = 1'b0;
    endtask

    // Called in the clear cycle; runs the commit to completion.
    task automatic finish_commit(input string tag);
        tick();
        expect_outs(6'b000111, {tag, " commit phase"});
        tick();
        tick();
        expect_outs(6'b000111, {tag, " commit held"});
        commit_done = 1'b1;
        tick();
        commit_done = 1'b0;
        expect_outs(6'b000100, {tag, " commit done"});
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        power_up();
        expect_outs(6'b000000, "R1 reset state");

        // R2/R5: basic reset, then R7 ignored repeat, R8 re-arm
        wr(KA, KD, 1'b1);
        expect_outs(6'b000000, "R2 first key write no effect");
        wr(KA, KD, 1'b1);
        expect_outs(6'b111101, "R2 clear pulse");
        finish_commit("R5");
        wr(KA, KD, 1'b1);
        wr(KA, KD, 1'b1);
        expect_outs(6'b000100, "R7 repeat key ignored");
        tick();
        expect_outs(6'b000100, "R7 lock persists");
        power_up();
        expect_outs(6'b000000, "R8 power-up releases lock");
        wr(KA, KD, 1'b1);
        wr(KA, KD, 1'b1);
        expect_outs(6'b111101, "R8 re-armed reset fires");
        finish_commit("R8");

        // R9: idle cycles between key writes
        power_up();
        wr(KA, KD, 1'b1);
        tick(); tick(); tick();
        wr(KA, KD, 1'b1);
        expect_outs(6'b111101, "R9 gap tolerated");
        // R6: key writes during busy are discarded
        tick();
        wr(KA, KD, 1'b1);
        wr(KA, KD, 1'b1);
        expect_outs(6'b000111, "R6 busy discards keys");
        commit_done = 1'b1;
        tick();
        commit_done = 1'b0;
        expect_outs(6'b000100, "R6 commit ends normally");

        // R4: reset_en low on completing write
        power_up();
        wr(KA, KD, 1'b1);
        wr(KA, KD, 1'b0);
        expect_outs(6'b000000, "R4 disabled key ignored");
        wr(KA, KD, 1'b1);
        expect_outs(6'b000000, "R4 detector back to idle");
        wr(KA, KD, 1'b1);
        expect_outs(6'b111101, "R4 fresh pair fires");

        // R3: intervening write breaks the key
        for (int a = 0; a < 32; a += 7) begin
            logic [4:0] ia;
            ia = (5'(a) == KA) ? 5'h00 : 5'(a);
            power_up();
            wr(KA, KD, 1'b1);
            wr(ia, KD, 1'b1);
            wr(KA, KD, 1'b1);
            expect_outs(6'b000000, "R3 interrupted key");
            wr(KA, KD, 1'b1);
            expect_outs(6'b111101, "R3 new pair after break");
        end

        // R3 sweep: every first byte at key address
        for (int d = 0; d < 256; d++) begin
            int exp;
            power_up();
            wr(KA, 8'(d), 1'b1);
            wr(KA, KD, 1'b1);
            exp = (8'(d) == KD) ? 6'b111101 : 6'b000000;
            expect_outs(exp, "R3 data sweep");
        end

        // R3 sweep: every address for a 0x55 first write
        for (int a = 0; a < 32; a++) begin
            int exp;
            power_up();
            wr(5'(a), KD, 1'b1);
            wr(KA, KD, 1'b1);
            exp = (5'(a) == KA) ? 6'b111101 : 6'b000000;
            expect_outs(exp, "R3 address sweep");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule